// File: doc/BRIEF.md
# Flash Status and Write-Guard Register

This block keeps the status byte of a serial flash memory model and decides whether each program or erase request may go ahead. It holds a write-enable latch, a busy flag, a two-bit protection level, a freeze bit for that level, a flag that marks an open word-program session, and two sticky locks that cover the first and the last 4 KB sector of the array.

A command decoder in front of the block turns each finished command frame into a one-cycle strobe. The strobes are write-enable, write-disable, status-write enable and status-write. A status-write carries the new data byte and is raised at the end of its frame. A request strobe carries a kind code and a byte address. The array engine raises a done strobe when a granted operation finishes. When a request is allowed, the block answers with a one-cycle `permit` pulse on the next clock. When it is refused, nothing is granted and the write-enable latch drops. The freeze pin is active low.

Top module: `flash_wp_status`

## Requirements
- R1: After reset the status byte reads 0x0C: protection level 11, every other bit 0. `permit` is low and both sector locks are clear.
- R2: Status bit 1 holds the write-enable latch. A write-enable strobe sets it when the block is idle. A write-disable strobe clears it, and also clears the session flag at bit 6.
- R3: A request arriving while the latch is 0 is refused. So is a request with kind code 6 or 7.
- R4: The protection level sits at status bits 3:2. Level 00 protects nothing. Level 01 protects addresses 0x30000 and above. Level 10 protects 0x20000 and above. Level 11 protects every address. A request that touches a protected byte is refused and clears the latch.
- R5: Kind codes are 0 for a byte, 1 for a word (2 bytes), 2 for a 4 KB sector, 3 for a 32 KB block, 4 for a 64 KB block and 5 for the whole chip. A request covers the aligned region of its size that holds the given address.
- R6: A chip erase is granted only when the level is 00 and both sector locks are clear.
- R7: The top lock is set by its strobe and the bottom lock by its own strobe. Only reset clears them. While set, they refuse any request touching 0x3F000–0x3FFFF or 0x00000–0x00FFF respectively.
- R8: A granted request gives a one-cycle `permit` pulse on the next clock and sets busy (status bit 0). The done strobe clears busy, and also clears the latch unless a session is open.
- R9: A granted word request sets the session flag (status bit 6). While the session is open, done leaves the latch set, so the next word can be granted without a new write-enable.
- R10: A status-write takes effect only if the strobe just before it was write-enable or status-write enable. It loads bits 3:2 and bit 7 of its data, ignores the other bits and clears the latch. Otherwise it changes nothing.
- R11: While bit 7 is 1 and `wp_n` is low, a status-write leaves bits 7 and 3:2 unchanged but still clears the latch.
- R12: While busy, requests and write-enable strobes are ignored: no permit is given and the status byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| ewsr_stb | input | 1 | Status-write enable command strobe |
| wrsr_stb | input | 1 | Status-write strobe, end of frame |
| wrsr_data | input | 8 | Data byte of the status-write |
| req_stb | input | 1 | Program or erase request strobe |
| req_kind | input | 3 | Request kind code (see R5) |
| req_addr | input | ADDR_W | Byte address of the request |
| done_stb | input | 1 | Granted operation has finished |
| top_lock_stb | input | 1 | Set the top-sector lock |
| bot_lock_stb | input | 1 | Set the bottom-sector lock |
| wp_n | input | 1 | Freeze pin, active low |
| permit | output | 1 | One-cycle grant pulse |
| status | output | 8 | Status byte |
| top_lock | output | 1 | Top-sector lock state |
| bot_lock | output | 1 | Bottom-sector lock state |

## Verification
The assertions assume that at most one strobe is high in any cycle. They also assume that done arrives only while the block is busy, as it would from an array engine that reacts only to `permit`. The stimulus drives every strobe for exactly one cycle, separated by idle cycles. It raises done only after a granted request, and it changes `wp_n` only in cycles that carry a command, so both assumptions hold throughout the run.

// File: rtl/flash_wp_status.sv
module flash_wp_status #(
  parameter int ADDR_W    = 18,
  parameter int SECTOR_AW = 12,
  parameter int BLK_S_AW  = 15,
  parameter int BLK_L_AW  = 16,
  parameter logic [1:0] RST_LEVEL = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              ewsr_stb,
  input  logic              wrsr_stb,
  input  logic [7:0]        wrsr_data,
  input  logic              req_stb,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              done_stb,
  input  logic              top_lock_stb,
  input  logic              bot_lock_stb,
  input  logic              wp_n,
  output logic              permit,
  output logic [7:0]        status,
  output logic              top_lock,
  output logic              bot_lock
);

  localparam logic [2:0] K_BYTE = 3'd0;
  localparam logic [2:0] K_WORD = 3'd1;
  localparam logic [2:0] K_SEC  = 3'd2;
  localparam logic [2:0] K_BLKS = 3'd3;
  localparam logic [2:0] K_BLKL = 3'd4;
  localparam logic [2:0] K_CHIP = 3'd5;

  localparam logic [ADDR_W-1:0] SEC_MASK  = {{(ADDR_W-SECTOR_AW){1'b0}}, {SECTOR_AW{1'b1}}};
  localparam logic [ADDR_W-1:0] BLKS_MASK = {{(ADDR_W-BLK_S_AW){1'b0}}, {BLK_S_AW{1'b1}}};
  localparam logic [ADDR_W-1:0] BLKL_MASK = {{(ADDR_W-BLK_L_AW){1'b0}}, {BLK_L_AW{1'b1}}};
  localparam logic [ADDR_W-1:0] TOP_SEC   = ~SEC_MASK;
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};

  logic       busy_q, wel_q, sess_q, bpl_q, arm_q, top_lock_q, bot_lock_q;
  logic [1:0] lvl_q;
  logic [ADDR_W-1:0] span, lo, hi;
  logic       lvl_hit, top_hit, bot_hit, kind_ok, grant, wrsr_ok, frozen, refused;

  logic unused_data;
  assign unused_data = ^{wrsr_data[6:4], wrsr_data[1:0]};

  always_comb begin
    case (req_kind)
      K_BYTE:  span = '0;
      K_WORD:  span = {{(ADDR_W-1){1'b0}}, 1'b1};
      K_SEC:   span = SEC_MASK;
      K_BLKS:  span = BLKS_MASK;
      K_BLKL:  span = BLKL_MASK;
      default: span = '1;
    endcase
  end

  assign lo = req_addr & ~span;
  assign hi = req_addr | span;

  always_comb begin
    case (lvl_q)
      2'b00:   lvl_hit = 1'b0;
      2'b01:   lvl_hit = hi >= QTR_BASE;
      2'b10:   lvl_hit = hi >= HALF_BASE;
      default: lvl_hit = 1'b1;
    endcase
  end

  assign top_hit = top_lock_q && (hi >= TOP_SEC);
  assign bot_hit = bot_lock_q && (lo <= SEC_MASK);
  assign kind_ok = req_kind <= K_CHIP;
  assign grant   = req_stb && !busy_q && wel_q && kind_ok && !lvl_hit && !top_hit && !bot_hit;
  assign refused = req_stb && !busy_q && !grant;
  assign wrsr_ok = wrsr_stb && arm_q;
  assign frozen  = bpl_q && !wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      wel_q      <= 1'b0;
      sess_q     <= 1'b0;
      bpl_q      <= 1'b0;
      arm_q      <= 1'b0;
      lvl_q      <= RST_LEVEL;
      top_lock_q <= 1'b0;
      bot_lock_q <= 1'b0;
      permit     <= 1'b0;
    end else begin
      permit <= grant;

      if ((wren_stb && !busy_q) || ewsr_stb)
        arm_q <= 1'b1;
      else if (wren_stb || wrdi_stb || wrsr_stb || req_stb)
        arm_q <= 1'b0;

      if (wrdi_stb)
        wel_q <= 1'b0;
      else if (wren_stb && !busy_q)
        wel_q <= 1'b1;
      else if (wrsr_ok || refused)
        wel_q <= 1'b0;
      else if (done_stb && busy_q && !sess_q)
        wel_q <= 1'b0;

      if (wrdi_stb || refused)
        sess_q <= 1'b0;
      else if (grant && req_kind == K_WORD)
        sess_q <= 1'b1;

      if (grant)
        busy_q <= 1'b1;
      else if (done_stb)
        busy_q <= 1'b0;

      if (wrsr_ok && !frozen) begin
        lvl_q <= wrsr_data[3:2];
        bpl_q <= wrsr_data[7];
      end

      if (top_lock_stb) top_lock_q <= 1'b1;
      if (bot_lock_stb) bot_lock_q <= 1'b1;
    end
  end

  assign status   = {bpl_q, sess_q, 2'b00, lvl_q, wel_q, busy_q};
  assign top_lock = top_lock_q;
  assign bot_lock = bot_lock_q;

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_stb, wrdi_stb, ewsr_stb, wrsr_stb, req_stb, done_stb, top_lock_stb, bot_lock_stb}));

  assert_done_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |-> busy_q);

  assert_permit_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> $past(wel_q));

  assert_permit_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> busy_q);

  assert_permit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    permit |=> !permit);

  assert_full_level_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> $past(lvl_q) != 2'b11);

  assert_chip_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && $past(req_kind) == K_CHIP) |->
      ($past(lvl_q) == 2'b00 && !$past(top_lock_q) && !$past(bot_lock_q)));

  assert_top_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_lock_q |=> top_lock_q);

  assert_bot_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bot_lock_q |=> bot_lock_q);

  assert_frozen_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bpl_q && !wp_n) |=> ($stable(lvl_q) && bpl_q));

  assert_busy_ignores_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_stb) |=> !permit);

endmodule

// File: tb/flash_wp_status_bench.sv
module flash_wp_status_bench;

  localparam int AW = 18;
  localparam int NV = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_stb = 0, wrdi_stb = 0, ewsr_stb = 0, wrsr_stb = 0;
  logic [7:0] wrsr_data = '0;
  logic req_stb = 0;
  logic [2:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic done_stb = 0, top_lock_stb = 0, bot_lock_stb = 0;
  logic wp_n = 1'b1;
  logic permit;
  logic [7:0] status;
  logic top_lock, bot_lock;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flash_wp_status u_flash_wp_status (
    .clk(clk), .rst_n(rst_n),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .ewsr_stb(ewsr_stb),
    .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .req_stb(req_stb), .req_kind(req_kind), .req_addr(req_addr),
    .done_stb(done_stb), .top_lock_stb(top_lock_stb), .bot_lock_stb(bot_lock_stb),
    .wp_n(wp_n), .permit(permit), .status(status),
    .top_lock(top_lock), .bot_lock(bot_lock)
  );

  // op: 0 idle, 1 wren, 2 wrdi, 3 ewsr, 4 wrsr, 5 req, 6 done, 7 top lock, 8 bottom lock
  // fields: op, kind, addr, data, wp_n, exp permit, exp status, exp {top,bot}, requirement
  localparam logic [48:0] VEC [NV] = '{
    {4'd5, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0C, 2'b00, 4'd3},  // R3 no latch
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0E, 2'b00, 4'd2},  // R2
    {4'd5, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0C, 2'b00, 4'd4},  // R4 level 11
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0E, 2'b00, 4'd2},
    {4'd4, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b00, 4'd10}, // R10 armed by wren
    {4'd4, 3'd0, 18'h00000, 8'h0C, 1'b1, 1'b0, 8'h00, 2'b00, 4'd10}, // R10 not armed
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b00, 4'd2},
    {4'd5, 3'd2, 18'h10000, 8'h00, 1'b1, 1'b1, 8'h03, 2'b00, 4'd8},  // R8 grant
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h03, 2'b00, 4'd12}, // R12
    {4'd5, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h03, 2'b00, 4'd12}, // R12
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b00, 4'd8},  // R8 done
    {4'd3, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b00, 4'd10},
    {4'd4, 3'd0, 18'h00000, 8'h04, 1'b1, 1'b0, 8'h04, 2'b00, 4'd10}, // R10 armed by ewsr
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h06, 2'b00, 4'd2},
    {4'd5, 3'd0, 18'h2FFFF, 8'h00, 1'b1, 1'b1, 8'h07, 2'b00, 4'd4},  // R4 below quarter
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h04, 2'b00, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h06, 2'b00, 4'd2},
    {4'd5, 3'd0, 18'h30000, 8'h00, 1'b1, 1'b0, 8'h04, 2'b00, 4'd4},  // R4 in quarter
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h06, 2'b00, 4'd2},
    {4'd5, 3'd4, 18'h20000, 8'h00, 1'b1, 1'b1, 8'h07, 2'b00, 4'd5},  // R5 64K below
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h04, 2'b00, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h06, 2'b00, 4'd2},
    {4'd5, 3'd5, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h04, 2'b00, 4'd6},  // R6 level 01
    {4'd3, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h04, 2'b00, 4'd10},
    {4'd4, 3'd0, 18'h00000, 8'h08, 1'b1, 1'b0, 8'h08, 2'b00, 4'd10},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0A, 2'b00, 4'd2},
    {4'd5, 3'd0, 18'h1FFFF, 8'h00, 1'b1, 1'b1, 8'h0B, 2'b00, 4'd4},  // R4 below half
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h08, 2'b00, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0A, 2'b00, 4'd2},
    {4'd5, 3'd3, 18'h18000, 8'h00, 1'b1, 1'b1, 8'h0B, 2'b00, 4'd5},  // R5 32K below half
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h08, 2'b00, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h0A, 2'b00, 4'd2},
    {4'd5, 3'd0, 18'h20000, 8'h00, 1'b1, 1'b0, 8'h08, 2'b00, 4'd4},  // R4 in half
    {4'd3, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h08, 2'b00, 4'd10},
    {4'd4, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b00, 4'd10},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b00, 4'd2},
    {4'd5, 3'd5, 18'h00000, 8'h00, 1'b1, 1'b1, 8'h03, 2'b00, 4'd6},  // R6 chip ok
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b00, 4'd8},
    {4'd8, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b01, 4'd7},  // R7 bottom set
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b01, 4'd2},
    {4'd5, 3'd3, 18'h07FFF, 8'h00, 1'b1, 1'b0, 8'h00, 2'b01, 4'd5},  // R5 aligned to 0
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b01, 4'd2},
    {4'd5, 3'd2, 18'h01000, 8'h00, 1'b1, 1'b1, 8'h03, 2'b01, 4'd7},  // R7 next sector
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b01, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b01, 4'd2},
    {4'd5, 3'd5, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b01, 4'd6},  // R6 lock blocks chip
    {4'd7, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b11, 4'd7},  // R7 top set
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b11, 4'd2},
    {4'd5, 3'd0, 18'h3F000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b11, 4'd7},  // R7 top sector
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b11, 4'd2},
    {4'd5, 3'd0, 18'h3EFFF, 8'h00, 1'b1, 1'b1, 8'h03, 2'b11, 4'd7},  // R7 just below
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b11, 4'd8},
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h02, 2'b11, 4'd2},
    {4'd5, 3'd1, 18'h10000, 8'h00, 1'b1, 1'b1, 8'h43, 2'b11, 4'd9},  // R9 session opens
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h42, 2'b11, 4'd9},  // R9 latch kept
    {4'd5, 3'd1, 18'h10002, 8'h00, 1'b1, 1'b1, 8'h43, 2'b11, 4'd9},  // R9 next word
    {4'd6, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h42, 2'b11, 4'd9},
    {4'd2, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b11, 4'd9},  // R9 R2 wrdi
    {4'd3, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h00, 2'b11, 4'd10},
    {4'd4, 3'd0, 18'h00000, 8'h8C, 1'b1, 1'b0, 8'h8C, 2'b11, 4'd11}, // R11 set freeze bit
    {4'd1, 3'd0, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8E, 2'b11, 4'd2},
    {4'd4, 3'd0, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8C, 2'b11, 4'd11}, // R11 frozen
    {4'd3, 3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h8C, 2'b11, 4'd10},
    {4'd4, 3'd0, 18'h00000, 8'h77, 1'b1, 1'b0, 8'h04, 2'b11, 4'd10}  // R10 R11 pin high
  };

  task automatic clear_strobes();
    wren_stb = 0; wrdi_stb = 0; ewsr_stb = 0; wrsr_stb = 0;
    req_stb = 0; done_stb = 0; top_lock_stb = 0; bot_lock_stb = 0;
  endtask

  task automatic check(input string tag, input logic p, input logic [7:0] s, input logic [1:0] l);
    applied++;
    if (permit !== p || status !== s || {top_lock, bot_lock} !== l) begin
      miscompares++;
      $display("FAIL %s: permit/status/locks = %b/%h/%b, expected %b/%h/%b",
               tag, permit, status, {top_lock, bot_lock}, p, s, l);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: cycles %0d, expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 8'h0C, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 8'h0C, 2'b00);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      case (v[48:45])
        4'd1: wren_stb = 1;
        4'd2: wrdi_stb = 1;
        4'd3: ewsr_stb = 1;
        4'd4: wrsr_stb = 1;
        4'd5: req_stb = 1;
        4'd6: done_stb = 1;
        4'd7: top_lock_stb = 1;
        4'd8: bot_lock_stb = 1;
        default: ;
      endcase
      req_kind  = v[44:42];
      req_addr  = v[41:24];
      wrsr_data = v[23:16];
      wp_n      = v[15];
      @(negedge clk);
      clear_strobes();
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      check(tag, v[14], v[13:6], v[5:4]);
    end

    // R1 R7: reset clears the locks and restores the status byte
    @(negedge clk);
    wp_n = 1'b1;
    check("R7 locks held", 1'b0, 8'h04, 2'b11);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 R7 mid-run reset", 1'b0, 8'h0C, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: status-write with no enable after reset is ignored
    wrsr_stb = 1; wrsr_data = 8'h00;
    @(negedge clk);
    clear_strobes();
    check("R10 unarmed after reset", 1'b0, 8'h0C, 2'b00);

    // R3: unknown kind refused even with latch set, level cleared first
    ewsr_stb = 1;
    @(negedge clk);
    clear_strobes();
    wrsr_stb = 1; wrsr_data = 8'h00;
    @(negedge clk);
    clear_strobes();
    wren_stb = 1;
    @(negedge clk);
    clear_strobes();
    check("R2 latch set", 1'b0, 8'h02, 2'b00);
    req_stb = 1; req_kind = 3'd6; req_addr = 18'h00100;
    @(negedge clk);
    clear_strobes();
    check("R3 kind 6 refused", 1'b0, 8'h00, 2'b00);

    // R8: permit lasts one cycle
    wren_stb = 1;
    @(negedge clk);
    clear_strobes();
    req_stb = 1; req_kind = 3'd0; req_addr = 18'h00100;
    @(negedge clk);
    clear_strobes();
    check("R8 permit high", 1'b1, 8'h03, 2'b00);
    @(negedge clk);
    check("R8 permit dropped", 1'b0, 8'h03, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule